// File: doc/BRIEF.md
# Wait-State Memory Slave with Burst Reads

This block is the memory side of a simple synchronous processor bus. A master opens a transfer by raising an address-enable line with an address and a read/write select. The slave answers after a programmable number of wait states by pulling an active-low ready strobe for one beat. On a read, the addressed word appears on the read-data lines in that beat. On a write, the write-data lines are stored in that beat. A small internal word array holds the data.

A read can also be a burst. While the master keeps a burst-low line asserted, one start address yields words from consecutive locations, one beat at a time. Every beat is preceded by the same number of wait states. The slave samples the burst line at the clock edge that closes each beat. A master that releases the line just after one beat has closed therefore still receives one more beat, and the burst stops after that. The idle bus rests in read mode, with address enable low and the ready strobe high. A new transfer needs address enable to be low for at least one cycle first.

The block is controlled by a four-state machine: `ST_IDLE`, `ST_WAIT`, `ST_BEAT` and `ST_HOLD`. The transitions are:

- **Start** (`ST_IDLE` to `ST_BEAT` or `ST_WAIT`): taken on a clock edge that sees address enable high. The target is `ST_BEAT` when the wait count is zero, otherwise `ST_WAIT`.
- **Wait expiry** (`ST_WAIT` to `ST_BEAT`): taken when the last wait cycle ends.
- **Burst continue** (`ST_BEAT` to `ST_BEAT` or `ST_WAIT`): taken on a read beat that closes with burst-low still asserted.
- **Complete** (`ST_BEAT` to `ST_HOLD`): taken when the final beat closes with address enable still high.
- **Release** (`ST_HOLD` to `ST_IDLE`): taken when address enable is seen low.
- **Abort** (`ST_WAIT` or `ST_BEAT` to `ST_IDLE`): taken when address enable is seen low in the middle of a transfer.

Top module: `bsl_slave`

## Requirements
- R1: After reset the ready strobe `bus_rdy_n` is high, read data is zero, and the machine is idle.
- R2: Whenever `bus_aen` is low, `bus_rdy_n` is high.
- R3: A read started with a wait count of 0 shows the addressed word on `bus_rdata`, with `bus_rdy_n` low, in the cycle right after the start edge.
- R4: The wait count `bus_wait` (0 to 7) is sampled at the start edge. With a count of N, `bus_rdy_n` stays high for N cycles after the start edge and goes low in the following cycle.
- R5: A single transfer gives exactly one cycle of `bus_rdy_n` low. The strobe then stays high for as long as `bus_aen` remains high.
- R6: A read whose first beat closes with `bus_burst_n` low (0 = burst) returns words from consecutive addresses beginning at the start address. Each beat is preceded by the same N wait cycles as the first.
- R7: A burst continues past a beat only if `bus_burst_n` is low at the edge that closes that beat. After the final beat, no further ready strobe appears.
- R8: Burst addresses wrap modulo the array depth, so 63 is followed by 0.
- R9: A write (`bus_rd` = 0) stores the value on `bus_wdata` at the edge that makes `bus_rdy_n` low. A write leaves `bus_rdata` unchanged.
- R10: Direction is latched at the start edge. A change of `bus_rd` during a transfer has no effect, and `bus_burst_n` has no effect on a write.
- R11: Dropping `bus_aen` before the beat aborts the transfer and returns the slave to idle. An aborted write leaves the array unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_aen | input | 1 | Address enable; high for the duration of a transfer |
| bus_rd | input | 1 | 1 = read, 0 = write |
| bus_addr | input | AW (6) | Word address of the transfer or burst start |
| bus_wdata | input | DW (16) | Write data |
| bus_burst_n | input | 1 | Active-low burst request for reads |
| bus_wait | input | WW (3) | Wait states inserted before each beat |
| bus_rdata | output | DW (16) | Read data, valid while `bus_rdy_n` is low on a read |
| bus_rdy_n | output | 1 | Active-low data-ready strobe |

## Verification
The case that matters most is when the closing of a burst beat and the master's change of the burst line fall in the same cycle. In a zero-wait burst, the master releases burst-low in exactly the cycle in which the next beat is already being delivered. The slave must deliver that beat and then stop. This is provoked with zero-wait and multi-wait bursts of several lengths, including one that wraps the address.

Each of these runs is judged on three things: the beat count, the gap before each beat, and the word in each beat. A watch window after the last beat must show no stray strobe. A second overlap is a direction or write-data change that lands during the wait cycles of a transfer. It is judged by reading the array back afterwards.

// File: rtl/bsl_pkg.sv
package bsl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_BEAT = 2'd2,
        ST_HOLD = 2'd3
    } bsl_state_e;

endpackage

// File: rtl/bsl_wait_ctr.sv
module bsl_wait_ctr #(
    parameter int WW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [WW-1:0] load_val,
    input  logic          dec,
    output logic          last
);

    logic [WW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // The final wait cycle is the one in which the count reads one.
    assign last = (cnt_q == WW'(1));

endmodule

// File: rtl/bsl_addr_seq.sv
module bsl_addr_seq #(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic          step,
    output logic [AW-1:0] next_addr,
    output logic [AW-1:0] addr_q
);

    // A step wraps naturally at the array depth.
    always_comb begin
        if (load) begin
            next_addr = load_addr;
        end else if (step) begin
            next_addr = addr_q + 1'b1;
        end else begin
            next_addr = addr_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else begin
            addr_q <= next_addr;
        end
    end

endmodule

// File: rtl/bsl_mem.sv
module bsl_mem #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            words[addr] <= wdata;
        end
    end

    // The read register changes only on a read beat.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= words[addr];
        end
    end

endmodule

// File: rtl/bsl_fsm.sv
module bsl_fsm
    import bsl_pkg::*;
#(
    parameter int WW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_aen,
    input  logic          bus_rd,
    input  logic          bus_burst_n,
    input  logic [WW-1:0] bus_wait,
    input  logic          wait_last,
    output bsl_state_e    state,
    output logic          rd_lat,
    output logic [WW-1:0] cfg_lat,
    output logic          cnt_load,
    output logic [WW-1:0] cnt_val,
    output logic          cnt_dec,
    output logic          addr_load,
    output logic          addr_step,
    output logic          mem_we,
    output logic          mem_re
);

    bsl_state_e state_d;
    logic       start;
    logic       cont;
    logic       go_beat;
    logic       rd_eff;

    // State register together with the values latched at the start edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            rd_lat  <= 1'b1;
            cfg_lat <= '0;
        end else begin
            state <= state_d;
            if (start) begin
                rd_lat  <= bus_rd;
                cfg_lat <= bus_wait;
            end
        end
    end

    // Next-state decision and control outputs.
    always_comb begin
        start   = (state == ST_IDLE) && bus_aen;
        cont    = (state == ST_BEAT) && bus_aen && rd_lat && !bus_burst_n;
        rd_eff  = start ? bus_rd : rd_lat;
        go_beat = 1'b0;
        state_d = state;
        unique case (state)
            ST_IDLE: begin
                if (bus_aen) begin
                    if (bus_wait == '0) begin
                        state_d = ST_BEAT;
                        go_beat = 1'b1;
                    end else begin
                        state_d = ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                if (!bus_aen) begin
                    state_d = ST_IDLE;
                end else if (wait_last) begin
                    state_d = ST_BEAT;
                    go_beat = 1'b1;
                end
            end
            ST_BEAT: begin
                if (!bus_aen) begin
                    state_d = ST_IDLE;
                end else if (cont) begin
                    if (cfg_lat == '0) begin
                        state_d = ST_BEAT;
                        go_beat = 1'b1;
                    end else begin
                        state_d = ST_WAIT;
                    end
                end else begin
                    state_d = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (!bus_aen) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        cnt_load  = start || cont;
        cnt_val   = start ? bus_wait : cfg_lat;
        cnt_dec   = (state == ST_WAIT);
        addr_load = start;
        addr_step = cont;
        mem_we    = go_beat && !rd_eff;
        mem_re    = go_beat && rd_eff;
    end

endmodule

// File: rtl/bsl_slave.sv
module bsl_slave
    import bsl_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 16,
    parameter int WW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_aen,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_burst_n,
    input  logic [WW-1:0] bus_wait,
    output logic [DW-1:0] bus_rdata,
    output logic          bus_rdy_n
);

    bsl_state_e    st;
    logic          rd_lat;
    logic [WW-1:0] cfg_lat;
    logic          cnt_load;
    logic [WW-1:0] cnt_val;
    logic          cnt_dec;
    logic          wait_last;
    logic          addr_load;
    logic          addr_step;
    logic [AW-1:0] addr_next;
    logic [AW-1:0] addr_cur;
    logic          mem_we;
    logic          mem_re;

    bsl_fsm #(.WW(WW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_aen    (bus_aen),
        .bus_rd     (bus_rd),
        .bus_burst_n(bus_burst_n),
        .bus_wait   (bus_wait),
        .wait_last  (wait_last),
        .state      (st),
        .rd_lat     (rd_lat),
        .cfg_lat    (cfg_lat),
        .cnt_load   (cnt_load),
        .cnt_val    (cnt_val),
        .cnt_dec    (cnt_dec),
        .addr_load  (addr_load),
        .addr_step  (addr_step),
        .mem_we     (mem_we),
        .mem_re     (mem_re)
    );

    bsl_wait_ctr #(.WW(WW)) u_wait (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cnt_load),
        .load_val(cnt_val),
        .dec     (cnt_dec),
        .last    (wait_last)
    );

    bsl_addr_seq #(.AW(AW)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (addr_load),
        .load_addr(bus_addr),
        .step     (addr_step),
        .next_addr(addr_next),
        .addr_q   (addr_cur)
    );

    bsl_mem #(.AW(AW), .DW(DW)) u_mem (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (mem_we),
        .re   (mem_re),
        .addr (addr_next),
        .wdata(bus_wdata),
        .rdata(bus_rdata)
    );

    // The strobe is gated by address enable, so it is released the moment the master lets go.
    assign bus_rdy_n = !((st == ST_BEAT) && bus_aen);

endmodule

// File: rtl/bsl_chk.sv
module bsl_chk
    import bsl_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 16,
    parameter int WW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_aen,
    input logic          bus_burst_n,
    input logic [WW-1:0] bus_wait,
    input logic [DW-1:0] bus_rdata,
    input logic          bus_rdy_n,
    input bsl_state_e    st,
    input logic          rd_lat,
    input logic [AW-1:0] addr_cur
);

    AST_RDY_NEEDS_AEN: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_aen |-> bus_rdy_n); // R2

    AST_ZERO_WAIT_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && bus_aen && bus_wait == '0) |=> (!bus_aen || !bus_rdy_n)); // R3

    AST_WAIT_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && bus_aen && bus_wait != '0) |=> bus_rdy_n); // R4

    AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BEAT && bus_aen && rd_lat && !bus_burst_n)
        |=> (addr_cur == AW'($past(addr_cur) + 1'b1))); // R6

    AST_LAST_BEAT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_BEAT && bus_aen && (!rd_lat || bus_burst_n)) |=> bus_rdy_n); // R7

    AST_WRITE_KEEPS_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rdy_n && !rd_lat) |-> $stable(bus_rdata)); // R9

    AST_DIR_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE) |=> (st == ST_IDLE || $stable(rd_lat))); // R10

    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE && !bus_aen) |=> (st == ST_IDLE)); // R11

endmodule

bind bsl_slave bsl_chk #(.AW(AW), .DW(DW), .WW(WW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_aen    (bus_aen),
    .bus_burst_n(bus_burst_n),
    .bus_wait   (bus_wait),
    .bus_rdata  (bus_rdata),
    .bus_rdy_n  (bus_rdy_n),
    .st         (st),
    .rd_lat     (rd_lat),
    .addr_cur   (addr_cur)
);

// File: tb/sim_bsl_slave.sv
module sim_bsl_slave;

    localparam int AW = 6;
    localparam int DW = 16;
    localparam int WW = 3;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          aen = 1'b0;
    logic          rd = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          burst_n = 1'b1;
    logic [WW-1:0] wcfg = '0;
    logic [DW-1:0] rdata;
    logic          rdy_n;

    logic [DW-1:0] mdl [DEPTH];
    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bsl_slave #(.AW(AW), .DW(DW), .WW(WW)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_aen    (aen),
        .bus_rd     (rd),
        .bus_addr   (addr),
        .bus_wdata  (wdata),
        .bus_burst_n(burst_n),
        .bus_wait   (wcfg),
        .bus_rdata  (rdata),
        .bus_rdy_n  (rdy_n)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic go_idle();
        aen = 1'b0;
        rd = 1'b1;
        burst_n = 1'b1;
        @(negedge clk);
        chk(rdy_n == 1'b1, "R2 strobe high with enable low", 32'(rdy_n), 32'd1);
    endtask

    task automatic do_write(input int a, input logic [DW-1:0] d, input int w, input bit bst_n);
        int n = 0;
        @(negedge clk);
        aen = 1'b1; rd = 1'b0; addr = AW'(a); wdata = d; wcfg = WW'(w); burst_n = bst_n;
        do begin @(negedge clk); n++; end while (rdy_n && n < 20);
        chk(n == w + 1, "R9 write strobe delay", 32'(n), 32'(w + 1));
        mdl[a] = d;
        if (!bst_n) begin
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                chk(rdy_n == 1'b1, "R10 burst line ignored on write", 32'(rdy_n), 32'd1);
            end
        end
        go_idle();
    endtask

    task automatic do_read(input int a, input int w);
        int n = 0;
        @(negedge clk);
        aen = 1'b1; rd = 1'b1; addr = AW'(a); wcfg = WW'(w); burst_n = 1'b1;
        do begin @(negedge clk); n++; end while (rdy_n && n < 20);
        chk(n == w + 1, (w == 0) ? "R3 zero-wait strobe delay" : "R4 wait-state strobe delay", 32'(n), 32'(w + 1));
        chk(rdata == mdl[a], (w == 0) ? "R3 zero-wait read data" : "R4 read data after waits", 32'(rdata), 32'(mdl[a]));
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            chk(rdy_n == 1'b1, "R5 single beat only", 32'(rdy_n), 32'd1);
        end
        go_idle();
    endtask

    task automatic do_burst(input int a, input int w, input int nb, input string tag);
        int beats = 0;
        int g = 0;
        int extra = 0;
        bit rel = 1'b0;
        @(negedge clk);
        aen = 1'b1; rd = 1'b1; addr = AW'(a); wcfg = WW'(w); burst_n = 1'b0;
        while (beats < nb && g < 20) begin
            @(negedge clk);
            if (beats == nb - 1 && !rel) begin
                burst_n = 1'b1;
                rel = 1'b1;
            end
            g++;
            if (!rdy_n) begin
                chk(g == w + 1, "R6 gap before beat", 32'(g), 32'(w + 1));
                chk(rdata == mdl[(a + beats) % DEPTH], tag, 32'(rdata), 32'(mdl[(a + beats) % DEPTH]));
                beats++;
                g = 0;
            end
        end
        chk(beats == nb, "R7 beat count", 32'(beats), 32'(nb));
        repeat (w + 3) begin
            @(negedge clk);
            if (!rdy_n) extra++;
        end
        chk(extra == 0, "R7 no beat after release", 32'(extra), 32'd0);
        go_idle();
    endtask

    task automatic test_reset();
        chk(rdy_n == 1'b1, "R1 reset strobe", 32'(rdy_n), 32'd1);
        chk(rdata == '0, "R1 reset read data", 32'(rdata), 32'd0);
        repeat (3) begin
            @(negedge clk);
            chk(rdy_n == 1'b1, "R2 idle strobe", 32'(rdy_n), 32'd1);
        end
    endtask

    task automatic test_fill();
        for (int i = 0; i < DEPTH; i++) begin
            do_write(i, DW'(16'hA000 ^ (i * 37)), i % 8, 1'b1);
        end
    endtask

    task automatic test_dir_flip();
        int n = 0;
        logic [DW-1:0] keep = mdl[5];
        @(negedge clk);
        aen = 1'b1; rd = 1'b1; addr = AW'(5); wcfg = WW'(3); burst_n = 1'b1;
        @(negedge clk);
        rd = 1'b0; wdata = 16'hDEAD;
        n = 1;
        while (rdy_n && n < 20) begin @(negedge clk); n++; end
        chk(rdata == keep, "R10 direction change ignored", 32'(rdata), 32'(keep));
        go_idle();
        do_read(5, 0);
    endtask

    task automatic test_abort();
        @(negedge clk);
        aen = 1'b1; rd = 1'b0; addr = AW'(9); wdata = 16'hBEEF; wcfg = WW'(5); burst_n = 1'b1;
        repeat (2) begin
            @(negedge clk);
            chk(rdy_n == 1'b1, "R11 no strobe before abort", 32'(rdy_n), 32'd1);
        end
        go_idle();
        repeat (6) begin
            @(negedge clk);
            chk(rdy_n == 1'b1, "R11 stays idle after abort", 32'(rdy_n), 32'd1);
        end
        do_read(9, 1);
    endtask

    task automatic test_late_wdata();
        int n = 0;
        @(negedge clk);
        aen = 1'b1; rd = 1'b0; addr = AW'(12); wdata = 16'h1111; wcfg = WW'(3); burst_n = 1'b1;
        @(negedge clk);
        wdata = 16'h2222;
        n = 1;
        while (rdy_n && n < 20) begin @(negedge clk); n++; end
        chk(n == 4, "R9 strobe after three waits", 32'(n), 32'd4);
        mdl[12] = 16'h2222;
        go_idle();
        do_read(12, 0);
    endtask

    task automatic test_write_burst_line();
        do_write(20, 16'h5A5A, 2, 1'b0);
        do_read(20, 0);
        do_read(21, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_fill();
        do_read(7, 0);
        do_read(30, 7);
        do_burst(2, 0, 4, "R6 zero-wait burst data");
        do_burst(40, 2, 5, "R6 waited burst data");
        do_burst(62, 1, 4, "R8 wrapped burst data");
        do_burst(17, 0, 1, "R7 one-beat burst data");
        test_dir_flip();
        test_abort();
        test_late_wdata();
        test_write_burst_line();
        done = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

endmodule